// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects up to 32 interrupt sources and raises one active-high request to the processor. It is programmed over a simple register bus with word-aligned byte offsets and separate read and write strobes. For each source, software sets a priority, a trigger type and a vector. Software can also enable or disable a source, and can set or clear its pending state. Read data appears on `rdata_o` one cycle after the read strobe.

When the processor takes the interrupt, software reads the vector register. That read returns the vector of the winning source. It also acknowledges the source, and the block pushes the source's priority and number onto an eight-level nesting stack. While a level is active, only a source with a strictly higher priority can raise the request again. A write to the end-of-interrupt register pops one level. When no interrupt qualifies, the vector read returns a programmable spurious vector and changes no state.

Source inputs are asynchronous. Each passes through a two-flop synchronizer before edge or level detection. The parameter `EXT_MASK` marks which sources are external. Low-level and falling-edge triggering are available only on external sources, and source 0 is always external.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is low. The enable mask, pending, core status, current-source and vector reads all return 0. Every mode register reads 0x40, which is high level with priority 0.
- R2: A mode register sits at offset 4*n and a vector register at 0x80+4*n. In the mode register, bits 2:0 hold the priority (0 lowest, 7 highest) and bits 6:5 hold the trigger type (0 low level, 1 falling edge, 2 high level, 3 rising edge). All other mode bits read 0.
- R3: On a source not marked external, a written trigger type 0 or 1 is stored as 2 or 3 (bit 6 is forced to 1). External sources, including source 0, keep the type as written.
- R4: A write to 0x120 sets enable bits for each 1 in the data, and a write to 0x124 clears them. Offset 0x110 reads back the enable mask.
- R5: Offset 0x10C reads the pending bits. On edge sources, a write to 0x12C sets pending bits and a write to 0x128 clears them. On level sources, the pending bit follows the synchronised input at its active level, and set writes have no effect.
- R6: An edge source becomes pending only on its configured edge, seen after synchronisation. The opposite edge leaves it unchanged.
- R7: The candidate is the source that is both pending and enabled with the highest priority; on a tie, the lowest source number wins. `irq_o` is high only when a candidate exists.
- R8: A read of 0x100 while `irq_o` is high returns the candidate's vector, pushes its priority, and clears its pending bit if it is an edge source.
- R9: A read of 0x100 while `irq_o` is low returns the spurious vector register at 0x134 and pushes nothing.
- R10: Offset 0x108 returns the source number at the top of the nesting stack, or 0 when the stack is empty.
- R11: Any write to 0x130 pops one nesting level. Eight such writes always empty the stack, and a write when the stack is empty has no effect.
- R12: While levels are active, `irq_o` rises only for a candidate whose priority is strictly greater than the top level. An equal priority waits.
- R13: Bit 0 of offset 0x114 mirrors `irq_o`. Offset 0x138 is a plain two-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 10 | Byte offset of the register, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after `rd_i` |
| src_i | input | N_SRC | Asynchronous interrupt source inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with all 32 sources, a nesting depth of 8, and `EXT_MASK` set to 0x3, so sources 0 and 1 are external. The extra external source makes falling-edge detection on a source other than 0 reachable. It also lets the bench check the type coercion on external and non-external sources side by side. With full depth, the bench can stack three levels, take a spurious read mid-nest, and then unwind it with eight end-of-interrupt writes plus one extra write on an empty stack. It also runs a tie between two equal-priority sources, a preemption by a higher level, and a wait behind an equal level.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PRIO_W = 3;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  localparam logic [ADDR_W-1:0] OFS_VEC_RD = 10'h100;
  localparam logic [ADDR_W-1:0] OFS_CUR    = 10'h108;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 10'h10C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 10'h110;
  localparam logic [ADDR_W-1:0] OFS_CORE   = 10'h114;
  localparam logic [ADDR_W-1:0] OFS_EN     = 10'h120;
  localparam logic [ADDR_W-1:0] OFS_DIS    = 10'h124;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 10'h128;
  localparam logic [ADDR_W-1:0] OFS_SET    = 10'h12C;
  localparam logic [ADDR_W-1:0] OFS_EOI    = 10'h130;
  localparam logic [ADDR_W-1:0] OFS_SPUR   = 10'h134;
  localparam logic [ADDR_W-1:0] OFS_DBG    = 10'h138;

endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] lvl_o,
  output logic [N_SRC-1:0] rise_o,
  output logic [N_SRC-1:0] fall_o
);

  logic [N_SRC-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= src_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;

endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
  parameter int unsigned N_SRC = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0][1:0] trig_i,
  input  logic [N_SRC-1:0]      lvl_i,
  input  logic [N_SRC-1:0]      rise_i,
  input  logic [N_SRC-1:0]      fall_i,
  input  logic [N_SRC-1:0]      set_i,
  input  logic [N_SRC-1:0]      clr_i,
  input  logic [N_SRC-1:0]      ack_i,
  output logic [N_SRC-1:0]      pend_o
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic pend_q;
    logic edge_hit, lvl_hit;

    // trig bit 1 selects the active-high polarity, bit 0 selects edge mode
    assign edge_hit = trig_i[i][1] ? rise_i[i] : fall_i[i];
    assign lvl_hit  = trig_i[i][1] ? lvl_i[i]  : ~lvl_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
      end else if (trig_i[i][0]) begin
        // a fresh edge in the same cycle as a clear is kept
        pend_q <= (pend_q & ~(clr_i[i] | ack_i[i])) | edge_hit | set_i[i];
      end else begin
        pend_q <= lvl_hit;
      end
    end

    assign pend_o[i] = pend_q;
  end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]             cand_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         valid_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [PRIO_W-1:0]            prio_o
);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    // strict compare keeps the lowest index on a tie
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_i[i] && (!valid_o || prio_i[i] > prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/prio_irq_nest.sv
module prio_irq_nest #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = 5,
  localparam int unsigned SP_W  = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [IDX_W-1:0]  push_idx_i,
  output logic              empty_o,
  output logic              full_o,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic [IDX_W-1:0]  top_idx_o,
  output logic [SP_W-1:0]   sp_o
);

  logic [DEPTH-1:0][PRIO_W-1:0] prio_q;
  logic [DEPTH-1:0][IDX_W-1:0]  idx_q;
  logic [SP_W-1:0]              sp_q;
  logic [PTR_W-1:0]             wr_ptr, top_ptr;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign wr_ptr  = PTR_W'(sp_q);
  assign top_ptr = PTR_W'(sp_q - SP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= '0;
      prio_q <= '0;
      idx_q  <= '0;
    end else if (push_i && !pop_i && !full_o) begin
      prio_q[wr_ptr] <= push_prio_i;
      idx_q[wr_ptr]  <= push_idx_i;
      sp_q           <= sp_q + SP_W'(1);
    end else if (pop_i && !push_i && !empty_o) begin
      sp_q <= sp_q - SP_W'(1);
    end
  end

  assign top_prio_o = empty_o ? '0 : prio_q[top_ptr];
  assign top_idx_o  = empty_o ? '0 : idx_q[top_ptr];
  assign sp_o       = sp_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned     N_SRC    = 32,
  parameter int unsigned     DEPTH    = 8,
  parameter logic [31:0]     EXT_MASK = 32'h0000_0001,
  localparam int unsigned    IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned    SP_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_o
);

  localparam logic [N_SRC-1:0] EXT = EXT_MASK[N_SRC-1:0] | N_SRC'(1);

  // ---------------- address decode ----------------
  logic       aligned, in_mode, in_vec;
  logic [4:0] reg_idx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_mode = aligned && (addr_i[ADDR_W-1:7] == '0);
  assign in_vec  = aligned && (addr_i[ADDR_W-1:7] == 3'b001);
  assign reg_idx = addr_i[6:2];

  logic wr_en, wr_dis, wr_clr, wr_set, wr_eoi, wr_spur, wr_dbg, rd_vec;
  assign wr_en   = wr_i && (addr_i == OFS_EN);
  assign wr_dis  = wr_i && (addr_i == OFS_DIS);
  assign wr_clr  = wr_i && (addr_i == OFS_CLR);
  assign wr_set  = wr_i && (addr_i == OFS_SET);
  assign wr_eoi  = wr_i && (addr_i == OFS_EOI);
  assign wr_spur = wr_i && (addr_i == OFS_SPUR);
  assign wr_dbg  = wr_i && (addr_i == OFS_DBG);
  assign rd_vec  = rd_i && (addr_i == OFS_VEC_RD);

  // ---------------- configuration registers ----------------
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [N_SRC-1:0][1:0]        trig_q;
  logic [N_SRC-1:0][DATA_W-1:0] vec_q;
  logic [N_SRC-1:0]             en_q;
  logic [DATA_W-1:0]            spur_q;
  logic [1:0]                   dbg_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_cfg
    logic mode_we, vec_we;
    logic [1:0] trig_wr;
    assign mode_we = wr_i && in_mode && (reg_idx == 5'(i));
    assign vec_we  = wr_i && in_vec  && (reg_idx == 5'(i));
    // internal sources cannot use the inverted polarities
    assign trig_wr = EXT[i] ? wdata_i[6:5] : {1'b1, wdata_i[5]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q[i] <= '0;
        trig_q[i] <= TRIG_HIGH;
        vec_q[i]  <= '0;
      end else begin
        if (mode_we) begin
          prio_q[i] <= wdata_i[PRIO_W-1:0];
          trig_q[i] <= trig_wr;
        end
        if (vec_we) vec_q[i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      spur_q <= '0;
      dbg_q  <= '0;
    end else begin
      if (wr_en)   en_q   <= en_q | wdata_i[N_SRC-1:0];
      if (wr_dis)  en_q   <= en_q & ~wdata_i[N_SRC-1:0];
      if (wr_spur) spur_q <= wdata_i;
      if (wr_dbg)  dbg_q  <= wdata_i[1:0];
    end
  end

  // ---------------- source path ----------------
  logic [N_SRC-1:0] lvl, rise, fall, pend, cand, ack_vec;
  logic [N_SRC-1:0] set_vec, clr_vec;

  assign set_vec = wr_set ? wdata_i[N_SRC-1:0] : '0;
  assign clr_vec = wr_clr ? wdata_i[N_SRC-1:0] : '0;

  prio_irq_sync #(.N_SRC(N_SRC)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  prio_irq_pend #(.N_SRC(N_SRC)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_q),
    .lvl_i  (lvl),
    .rise_i (rise),
    .fall_i (fall),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .ack_i  (ack_vec),
    .pend_o (pend)
  );

  assign cand = pend & en_q;

  logic              best_valid;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;

  prio_irq_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_arb (
    .cand_i  (cand),
    .prio_i  (prio_q),
    .valid_o (best_valid),
    .idx_o   (best_idx),
    .prio_o  (best_prio)
  );

  // ---------------- nesting ----------------
  logic              nest_empty, nest_full, push, pop;
  logic [PRIO_W-1:0] top_prio;
  logic [IDX_W-1:0]  top_idx;
  logic [SP_W-1:0]   nest_sp;

  assign irq_o   = best_valid && !nest_full && (nest_empty || best_prio > top_prio);
  assign push    = rd_vec && irq_o;
  assign pop     = wr_eoi && !nest_empty;
  assign ack_vec = push ? (N_SRC'(1) << best_idx) : '0;

  prio_irq_nest #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_nest (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_prio_i (best_prio),
    .push_idx_i  (best_idx),
    .empty_o     (nest_empty),
    .full_o      (nest_full),
    .top_prio_o  (top_prio),
    .top_idx_o   (top_idx),
    .sp_o        (nest_sp)
  );

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (in_mode) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (reg_idx == 5'(i)) begin
          rd_val[PRIO_W-1:0] = prio_q[i];
          rd_val[6:5]        = trig_q[i];
        end
      end
    end else if (in_vec) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (reg_idx == 5'(i)) rd_val = vec_q[i];
      end
    end else begin
      unique case (addr_i)
        OFS_VEC_RD: rd_val = irq_o ? vec_q[best_idx] : spur_q;
        OFS_CUR:    rd_val[IDX_W-1:0] = top_idx;
        OFS_PEND:   rd_val[N_SRC-1:0] = pend;
        OFS_MASK:   rd_val[N_SRC-1:0] = en_q;
        OFS_CORE:   rd_val[0] = irq_o;
        OFS_SPUR:   rd_val = spur_q;
        OFS_DBG:    rd_val[1:0] = dbg_q;
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned  N_SRC  = 32,
  parameter int unsigned  DEPTH  = 8,
  parameter int unsigned  PRIO_W = 3,
  parameter logic [31:0]  EXT_MASK = 32'h1,
  localparam int unsigned IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned SP_W   = $clog2(DEPTH + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  irq_i,
  input logic [N_SRC-1:0]      cand_i,
  input logic                  push_i,
  input logic                  pop_i,
  input logic [SP_W-1:0]       sp_i,
  input logic [IDX_W-1:0]      best_idx_i,
  input logic [PRIO_W-1:0]     best_prio_i,
  input logic [IDX_W-1:0]      top_idx_i,
  input logic [PRIO_W-1:0]     top_prio_i,
  input logic [N_SRC-1:0][1:0] trig_i
);

  localparam logic [N_SRC-1:0] EXT = EXT_MASK[N_SRC-1:0] | N_SRC'(1);

  logic [N_SRC-1:0] pol_hi;
  always_comb for (int i = 0; i < N_SRC; i++) pol_hi[i] = trig_i[i][1];

  // R7
  irq_needs_cand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (cand_i != '0));

  // R8
  ack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (sp_i == $past(sp_i) + SP_W'(1)) && (top_idx_i == $past(best_idx_i))
               && (top_prio_i == $past(best_prio_i)));

  // R11
  eoi_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> (sp_i == $past(sp_i) - SP_W'(1)));

  // R11
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_i <= SP_W'(DEPTH));

  // R12
  strict_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && sp_i != '0) |-> (best_prio_i > top_prio_i));

  // R3
  internal_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &(pol_hi | EXT));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .N_SRC(N_SRC), .DEPTH(DEPTH), .PRIO_W(prio_irq_pkg::PRIO_W), .EXT_MASK(EXT_MASK)
) i_prio_irq_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_o),
  .cand_i      (cand),
  .push_i      (push),
  .pop_i       (pop),
  .sp_i        (nest_sp),
  .best_idx_i  (best_idx),
  .best_prio_i (best_prio),
  .top_idx_i   (top_idx),
  .top_prio_i  (top_prio),
  .trig_i      (trig_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

  localparam int unsigned N = 32;

  localparam logic [9:0] A_VEC  = 10'h100, A_CUR = 10'h108, A_PEND = 10'h10C,
                         A_MASK = 10'h110, A_CORE = 10'h114, A_EN = 10'h120,
                         A_DIS  = 10'h124, A_CLR = 10'h128, A_SET = 10'h12C,
                         A_EOI  = 10'h130, A_SPUR = 10'h134, A_DBG = 10'h138;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] src = '0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N), .DEPTH(8), .EXT_MASK(32'h3)) i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [9:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_tests++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq_o got %b expected %b", t, irq, e);
    end
  endtask

  task automatic settle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    settle(3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    settle(200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd_reg(A_MASK, 32'h0, "R1 mask");
    rd_reg(A_PEND, 32'h0, "R1 pending");
    rd_reg(A_CORE, 32'h0, "R1 core status");
    rd_reg(A_VEC,  32'h0, "R1 vector");
    rd_reg(A_CUR,  32'h0, "R1 current");
    rd_reg(10'h014, 32'h40, "R1 mode reset");

    // R9 spurious
    wr_reg(A_SPUR, 32'hDEAD_0001);
    rd_reg(A_VEC, 32'hDEAD_0001, "R9 spurious read");
    rd_reg(A_CUR, 32'h0, "R9 no push");

    for (int n = 0; n < N; n++) wr_reg(10'(10'h080 + 4 * n), 32'hA000_0000 | n);
    rd_reg(10'h0B4, 32'hA000_000D, "R2 vector reg");

    // R2 mode fields
    wr_reg(10'h01C, 32'hFFFF_FFFF);
    rd_reg(10'h01C, 32'h67, "R2 mode mask");
    wr_reg(10'h014, 32'h65);
    rd_reg(10'h014, 32'h65, "R2 mode readback");

    // R3 type coercion
    wr_reg(10'h014, 32'h25);
    rd_reg(10'h014, 32'h65, "R3 internal falling");
    wr_reg(10'h004, 32'h24);
    rd_reg(10'h004, 32'h24, "R3 external falling");
    wr_reg(10'h008, 32'h03);
    rd_reg(10'h008, 32'h43, "R3 internal low");
    wr_reg(10'h000, 32'h07);
    rd_reg(10'h000, 32'h07, "R3 source0 low");
    settle(2);
    rd_reg(A_PEND, 32'h1, "R5 low level active");
    wr_reg(10'h000, 32'h40);
    settle(2);
    rd_reg(A_PEND, 32'h0, "R5 level follows type");

    // R4 enable/disable
    wr_reg(A_EN, 32'hF0);
    wr_reg(A_DIS, 32'h30);
    rd_reg(A_MASK, 32'hC0, "R4 mask");
    wr_reg(A_DIS, 32'hFFFF_FFFF);
    rd_reg(A_MASK, 32'h0, "R4 mask cleared");

    // R5 set/clear on edge, level ignores set
    wr_reg(10'h00C, 32'h62);
    wr_reg(A_SET, 32'h8);
    rd_reg(A_PEND, 32'h8, "R5 set");
    wr_reg(A_CLR, 32'h8);
    rd_reg(A_PEND, 32'h0, "R5 clear");
    wr_reg(10'h024, 32'h40);
    wr_reg(A_SET, 32'h200);
    settle(2);
    rd_reg(A_PEND, 32'h0, "R5 set on level ignored");
    src[9] = 1'b1; settle(4);
    rd_reg(A_PEND, 32'h200, "R5 level high");
    src[9] = 1'b0; settle(4);
    rd_reg(A_PEND, 32'h0, "R5 level drop");

    // R6 edges
    src[3] = 1'b1; settle(4);
    rd_reg(A_PEND, 32'h8, "R6 rising");
    src[3] = 1'b0; settle(4);
    rd_reg(A_PEND, 32'h8, "R6 falling on rising source");
    wr_reg(A_CLR, 32'h8);
    src[1] = 1'b1; settle(4);
    rd_reg(A_PEND, 32'h0, "R6 rise on falling source");
    src[1] = 1'b0; settle(4);
    rd_reg(A_PEND, 32'h2, "R6 falling external");
    wr_reg(A_CLR, 32'h2);

    // R7 R8 R10 R12 arbitration and nesting
    wr_reg(10'h010, 32'h63);
    wr_reg(10'h018, 32'h63);
    wr_reg(10'h020, 32'h66);
    wr_reg(A_SET, 32'h150);
    chk_irq(1'b0, "R7 masked pending");
    wr_reg(A_EN, 32'h150);
    chk_irq(1'b1, "R7 candidate");
    rd_reg(A_CORE, 32'h1, "R13 core status");
    rd_reg(A_VEC, 32'hA000_0008, "R8 highest priority");
    chk_irq(1'b0, "R12 lower waits");
    rd_reg(A_CUR, 32'h8, "R10 current");
    rd_reg(A_PEND, 32'h50, "R8 edge pending cleared");
    wr_reg(A_EOI, 32'h0);
    chk_irq(1'b1, "R11 pop re-enables");
    rd_reg(A_VEC, 32'hA000_0004, "R7 tie lowest index");
    rd_reg(A_CUR, 32'h4, "R10 current tie");
    chk_irq(1'b0, "R12 equal waits");
    wr_reg(10'h028, 32'h65);
    wr_reg(A_SET, 32'h400);
    wr_reg(A_EN, 32'h400);
    chk_irq(1'b1, "R12 higher preempts");
    rd_reg(A_VEC, 32'hA000_000A, "R8 preempt vector");
    rd_reg(A_CUR, 32'hA, "R10 nested current");
    wr_reg(A_EOI, 32'h0);
    rd_reg(A_CUR, 32'h4, "R11 unwind one");
    chk_irq(1'b0, "R12 still equal");
    wr_reg(A_EOI, 32'h0);
    rd_reg(A_CUR, 32'h0, "R10 empty");
    chk_irq(1'b1, "R7 remaining source");
    rd_reg(A_VEC, 32'hA000_0006, "R8 last source");
    wr_reg(A_EOI, 32'h0);
    chk_irq(1'b0, "R7 nothing pending");

    // R11 eight EOIs clear nesting
    wr_reg(10'h040, 32'h61);
    wr_reg(10'h044, 32'h62);
    wr_reg(10'h048, 32'h63);
    wr_reg(A_EN, 32'h7_0000);
    wr_reg(A_SET, 32'h1_0000);
    rd_reg(A_VEC, 32'hA000_0010, "R8 level1");
    wr_reg(A_SET, 32'h2_0000);
    rd_reg(A_VEC, 32'hA000_0011, "R8 level2");
    wr_reg(A_SET, 32'h4_0000);
    rd_reg(A_VEC, 32'hA000_0012, "R8 level3");
    rd_reg(A_CUR, 32'h12, "R10 three deep");
    rd_reg(A_VEC, 32'hDEAD_0001, "R9 spurious while nested");
    rd_reg(A_CUR, 32'h12, "R9 no push nested");
    for (int k = 0; k < 8; k++) wr_reg(A_EOI, 32'h0);
    rd_reg(A_CUR, 32'h0, "R11 eight EOIs");
    chk_irq(1'b0, "R11 idle");
    wr_reg(A_EOI, 32'h0);
    chk_irq(1'b0, "R11 EOI on empty");
    wr_reg(A_SET, 32'h1_0000);
    chk_irq(1'b1, "R11 lowest prio after clear");
    rd_reg(A_VEC, 32'hA000_0010, "R11 reack");
    rd_reg(A_CUR, 32'h10, "R10 after reack");
    wr_reg(A_EOI, 32'h0);

    // R13 debug register
    rd_reg(A_CORE, 32'h0, "R13 core idle");
    wr_reg(A_DBG, 32'h3);
    rd_reg(A_DBG, 32'h3, "R13 debug set");
    wr_reg(A_DBG, 32'hFFFF_FFFC);
    rd_reg(A_DBG, 32'h0, "R13 debug clear");

    finish_run();
  end

endmodule